// File: doc/BRIEF.md
# Variable-Length CAN Receive Record FIFO

This block holds received CAN frames as packed byte records in a circular byte buffer. Every record begins with a frame-information byte. Bit 7 of that byte is the extended-frame flag, bit 6 is the remote-frame flag, and bits 3..0 are the data length code. The information byte is followed by the identifier bytes and then the payload.

An extended record carries identifier bits 28..21, then 20..13, then 12..5, then bits 4..0 left-justified in bits 7..3. A standard record carries identifier bits 10..3, then bits 2..0 in bits 7..5.

Upstream logic delivers each accepted record as a byte stream and marks its first byte. The block works out the record length from that first byte. A record that does not fit in the buffer is dropped whole, and the overrun flags are raised.

The host sees a thirteen-byte window that begins at the oldest record. It removes the oldest record with a release command. The release moves the read position forward by that record's own length, which is computed from the information byte at the head of the buffer.

Top module: `can_rx_fifo`

## Requirements
- R1: While reset is asserted, and in the cycle after it, byte count, message count and every flag read zero.
- R2: A record's length is 3 bytes, plus 2 when info bit 7 is set, plus the data length code (bits 3..0, values above 8 count as 8) when info bit 6 is clear. At the edge of its last byte, byte count grows by that length and message count by one.
- R3: Both the receive-buffer-status flag and the receive interrupt flag rise after a store. They fall when a release brings the message count to zero.
- R4: A record is refused whole when, at its first byte, the current byte count plus its length exceeds the buffer size. A refusal leaves the counts and stored bytes unchanged and sets the overrun status and overrun interrupt flags one cycle later. A record that fills the buffer exactly is accepted.
- R5: A clear-overrun command clears both overrun flags. An overrun event in the same cycle takes precedence.
- R6: A release while the message count is zero changes nothing.
- R7: A release advances the start position by the head record's length, reduces the byte count by that length and decrements the message count.
- R8: One cycle after read offset k (0..12) is presented, the read data equals the buffer byte at (start + k) modulo the buffer size. Offsets 13..15 return zero.
- R9: The write position and the start position wrap modulo the buffer size, so a record split across the end of the buffer reads back intact.
- R10: The receiving flag is high from the cycle after the first byte of an accepted record until the edge of its last byte. It stays low for a refused record.
- R11: A release in the same cycle as a store's last byte applies both changes to the counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Record byte valid |
| in_sof | input | 1 | Marks the first (information) byte of a record |
| in_data | input | 8 | Record byte |
| rel_cmd | input | 1 | Release the oldest record |
| clr_ovr_cmd | input | 1 | Clear the overrun flags |
| rd_off | input | 4 | Window offset to read |
| rd_data | output | 8 | Window byte, one cycle after rd_off |
| byte_count | output | $clog2(DEPTH+1) | Bytes held in stored records |
| msg_count | output | $clog2(DEPTH+1) | Records held |
| rx_status | output | 1 | Receive buffer holds at least one record |
| rx_irq | output | 1 | Receive interrupt flag |
| ovr_status | output | 1 | Overrun status flag |
| ovr_irq | output | 1 | Overrun interrupt flag |
| receiving | output | 1 | A record is being written |

## Verification
The main loop stores and releases nine records whose information bytes cover these cases:
- standard and extended frames;
- remote frames with non-zero length codes, which have no payload;
- zero-length data frames;
- length codes above eight.

This separates the identifier term, the remote-frame term and the length cap in the length rule. Because the records add up to more than the buffer size, the later window reads cross the end of the buffer.

Directed sequences then cover the overrun boundary, a refusal against an exact fit, a release on an empty buffer, offsets beyond the window, and a release that lands on the last byte of a store.

// File: rtl/can_rx_fifo_pkg.sv
package can_rx_fifo_pkg;
  localparam int WIN_BYTES = 13;
  localparam int MAX_DLC   = 8;
  localparam int LEN_W     = 5;

  // Record length in bytes from the frame-information byte.
  function automatic logic [LEN_W-1:0] rec_len(input logic [7:0] info);
    logic [LEN_W-1:0] dl;
    logic [LEN_W-1:0] n;
    dl = (info[3:0] > 4'(MAX_DLC)) ? LEN_W'(MAX_DLC) : LEN_W'(info[3:0]);
    n  = LEN_W'(3);
    if (info[7]) n = n + LEN_W'(2);
    if (!info[6]) n = n + dl;
    return n;
  endfunction
endpackage

// File: rtl/can_rx_fifo_ram.sv
module can_rx_fifo_ram #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_q,
  input  logic [AW-1:0] head_addr,
  output logic [7:0]    head_byte
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_q <= mem[rd_addr];
  end

  // Head information byte, read without a clock so back-to-back
  // releases always see the current head.
  assign head_byte = mem[head_addr];
endmodule

// File: rtl/can_rx_fifo_ingest.sv
module can_rx_fifo_ingest
  import can_rx_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic [7:0]       in_data,
  input  logic [CW-1:0]    byte_count,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [7:0]       wr_data,
  output logic             commit,
  output logic [LEN_W-1:0] commit_len,
  output logic             ovr_evt,
  output logic             receiving
);
  logic [AW-1:0]    wr_ptr;
  logic [3:0]       idx;
  logic [LEN_W-1:0] cur_len;
  logic             active;
  logic [LEN_W-1:0] sof_len;
  logic [CW:0]      need;
  logic             fits, start_ok, cont;

  always_comb begin
    sof_len  = rec_len(in_data);
    need     = {1'b0, byte_count} + (CW+1)'(sof_len);
    fits     = need <= (CW+1)'(DEPTH);
    start_ok = in_valid && in_sof && fits;
    ovr_evt  = in_valid && in_sof && !fits;
    cont     = in_valid && !in_sof && active;
    wr_en    = start_ok || cont;
    wr_addr  = wr_ptr + (in_sof ? '0 : AW'(idx));
    wr_data  = in_data;
    commit   = cont && (LEN_W'(idx) == cur_len - LEN_W'(1));
    commit_len = cur_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      idx     <= '0;
      cur_len <= '0;
      active  <= 1'b0;
    end else if (start_ok) begin
      active  <= 1'b1;
      idx     <= 4'd1;
      cur_len <= sof_len;
    end else if (ovr_evt) begin
      active  <= 1'b0;
    end else if (cont) begin
      if (commit) begin
        active <= 1'b0;
        wr_ptr <= wr_ptr + AW'(cur_len);
      end else begin
        idx <= idx + 4'd1;
      end
    end
  end

  assign receiving = active;
endmodule

// File: rtl/can_rx_fifo_track.sv
module can_rx_fifo_track
  import can_rx_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic [LEN_W-1:0] commit_len,
  input  logic             ovr_evt,
  input  logic             rel_cmd,
  input  logic             clr_ovr_cmd,
  input  logic [7:0]       head_byte,
  output logic [AW-1:0]    start,
  output logic [CW-1:0]    byte_count,
  output logic [CW-1:0]    msg_count,
  output logic             rx_status,
  output logic             rx_irq,
  output logic             ovr_status,
  output logic             ovr_irq
);
  logic             rel_ok;
  logic [LEN_W-1:0] rel_len;
  logic [CW-1:0]    bc_next, mc_next;

  always_comb begin
    rel_ok  = rel_cmd && (msg_count != '0);
    rel_len = rec_len(head_byte);
    bc_next = byte_count
            + (commit ? CW'(commit_len) : '0)
            - (rel_ok ? CW'(rel_len) : '0);
    mc_next = msg_count + CW'(commit) - CW'(rel_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start      <= '0;
      byte_count <= '0;
      msg_count  <= '0;
      rx_status  <= 1'b0;
      rx_irq     <= 1'b0;
      ovr_status <= 1'b0;
      ovr_irq    <= 1'b0;
    end else begin
      byte_count <= bc_next;
      msg_count  <= mc_next;
      if (rel_ok) start <= start + AW'(rel_len);
      if (commit) begin
        rx_status <= 1'b1;
        rx_irq    <= 1'b1;
      end else if (rel_ok && mc_next == '0) begin
        rx_status <= 1'b0;
        rx_irq    <= 1'b0;
      end
      if (ovr_evt) begin
        ovr_status <= 1'b1;
        ovr_irq    <= 1'b1;
      end else if (clr_ovr_cmd) begin
        ovr_status <= 1'b0;
        ovr_irq    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/can_rx_fifo.sv
module can_rx_fifo
  import can_rx_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic [7:0]    in_data,
  input  logic          rel_cmd,
  input  logic          clr_ovr_cmd,
  input  logic [3:0]    rd_off,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] byte_count,
  output logic [CW-1:0] msg_count,
  output logic          rx_status,
  output logic          rx_irq,
  output logic          ovr_status,
  output logic          ovr_irq,
  output logic          receiving
);
  logic             wr_en, commit, ovr_evt, off_ok_q;
  logic [AW-1:0]    wr_addr, start;
  logic [7:0]       wr_data, ram_q, head_byte;
  logic [LEN_W-1:0] commit_len;

  can_rx_fifo_ingest #(.DEPTH(DEPTH)) u_ingest (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .in_data(in_data), .byte_count(byte_count), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .commit(commit),
    .commit_len(commit_len), .ovr_evt(ovr_evt), .receiving(receiving)
  );

  can_rx_fifo_track #(.DEPTH(DEPTH)) u_track (
    .clk(clk), .rst(rst), .commit(commit), .commit_len(commit_len),
    .ovr_evt(ovr_evt), .rel_cmd(rel_cmd), .clr_ovr_cmd(clr_ovr_cmd),
    .head_byte(head_byte), .start(start), .byte_count(byte_count),
    .msg_count(msg_count), .rx_status(rx_status), .rx_irq(rx_irq),
    .ovr_status(ovr_status), .ovr_irq(ovr_irq)
  );

  can_rx_fifo_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(start + AW'(rd_off)), .rd_q(ram_q),
    .head_addr(start), .head_byte(head_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) off_ok_q <= 1'b0;
    else     off_ok_q <= (rd_off < 4'(WIN_BYTES));
  end

  assign rd_data = off_ok_q ? ram_q : 8'h00;
endmodule

// File: rtl/can_rx_fifo_chk.sv
module can_rx_fifo_chk #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_sof,
  input logic          rel_cmd,
  input logic          clr_ovr_cmd,
  input logic [CW-1:0] byte_count,
  input logic [CW-1:0] msg_count,
  input logic          rx_status,
  input logic          ovr_status,
  input logic          receiving
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (byte_count == '0 && msg_count == '0 && !rx_status && !ovr_status && !receiving));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    byte_count <= CW'(DEPTH));

  assert_ovr_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_status) |-> $past(in_valid && in_sof));

  assert_ovr_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_ovr_cmd && !in_sof) |=> !ovr_status);

  assert_empty_release_R6: assert property (@(posedge clk) disable iff (rst)
    (rel_cmd && msg_count == '0 && !in_valid) |=> ($stable(byte_count) && $stable(msg_count)));

  assert_rx_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_status) |-> (msg_count == '0 && $past(rel_cmd)));

  assert_recv_rise_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(receiving) |-> $past(in_valid && in_sof));

  assert_msg_step_R11: assert property (@(posedge clk) disable iff (rst)
    (msg_count == $past(msg_count)) || (msg_count == $past(msg_count) + 1'b1) ||
    (msg_count == $past(msg_count) - 1'b1));
endmodule

bind can_rx_fifo can_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
  .rel_cmd(rel_cmd), .clr_ovr_cmd(clr_ovr_cmd), .byte_count(byte_count),
  .msg_count(msg_count), .rx_status(rx_status), .ovr_status(ovr_status),
  .receiving(receiving)
);

// File: tb/tb_can_rx_fifo.sv
module tb_can_rx_fifo;
  localparam int CLK_P = 10;
  localparam int DEPTH = 64;
  localparam int CW = $clog2(DEPTH + 1);
  // {info byte, expected record length}
  localparam logic [12:0] VEC [9] = '{
    {8'h08, 5'd11}, {8'h00, 5'd3}, {8'h48, 5'd3}, {8'h88, 5'd13}, {8'hC5, 5'd5},
    {8'h83, 5'd8},  {8'h0F, 5'd11}, {8'h02, 5'd5}, {8'h8A, 5'd13}
  };

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_sof = 0, rel_cmd = 0, clr_ovr_cmd = 0;
  logic [7:0] in_data = 0;
  logic [3:0] rd_off = 0;
  logic [7:0] rd_data;
  logic [CW-1:0] byte_count, msg_count;
  logic rx_status, rx_irq, ovr_status, ovr_irq, receiving;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  can_rx_fifo #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
    .rel_cmd(rel_cmd), .clr_ovr_cmd(clr_ovr_cmd), .rd_off(rd_off), .rd_data(rd_data),
    .byte_count(byte_count), .msg_count(msg_count), .rx_status(rx_status),
    .rx_irq(rx_irq), .ovr_status(ovr_status), .ovr_irq(ovr_irq), .receiving(receiving)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int tag, input int k);
    return 8'((tag * 16 + k * 7 + 3) & 255);
  endfunction

  task automatic send_rec(input logic [7:0] info, input int n, input int tag,
                          input bit rel_last, input int exp_acc);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == 1) chk("R10 receiving mid-record", int'(receiving), exp_acc);
      in_valid = 1;
      in_sof   = (k == 0);
      in_data  = (k == 0) ? info : pat(tag, k);
      rel_cmd  = rel_last && (k == n - 1);
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; rel_cmd = 0;
    chk("R10 receiving after record", int'(receiving), 0);
  endtask

  task automatic do_release();
    @(negedge clk); rel_cmd = 1;
    @(negedge clk); rel_cmd = 0;
  endtask

  task automatic read_at(input int off, output int val);
    @(negedge clk); rd_off = 4'(off);
    @(negedge clk); val = int'(rd_data);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (5) @(negedge clk);
    chk("R1 byte_count", int'(byte_count), 0);
    chk("R1 msg_count", int'(msg_count), 0);
    chk("R1 flags", int'({rx_status, rx_irq, ovr_status, ovr_irq, receiving}), 0);
    rst = 0;
    @(negedge clk);
    do_release();
    chk("R6 empty release byte_count", int'(byte_count), 0);
    chk("R6 empty release msg_count", int'(msg_count), 0);

    // Table walk: store, read whole window, release.
    for (int i = 0; i < 9; i++) begin
      logic [7:0] info;
      int len;
      info = VEC[i][12:5];
      len  = int'(VEC[i][4:0]);
      send_rec(info, len, i, 0, 1);
      chk("R2 byte_count after store", int'(byte_count), len);
      chk("R2 msg_count after store", int'(msg_count), 1);
      chk("R3 rx flags set", int'({rx_status, rx_irq}), 3);
      for (int k = 0; k < len; k++) begin
        read_at(k, v);
        chk("R8_R9 window byte", v, int'((k == 0) ? info : pat(i, k)));
      end
      do_release();
      chk("R7 byte_count after release", int'(byte_count), 0);
      chk("R7 msg_count after release", int'(msg_count), 0);
      chk("R3 rx flags cleared", int'({rx_status, rx_irq}), 0);
    end

    // Overrun boundary.
    for (int j = 0; j < 4; j++) send_rec(8'h88, 13, 20 + j, 0, 1);
    send_rec(8'h08, 11, 24, 0, 1);
    chk("R2 filled byte_count", int'(byte_count), 63);
    send_rec(8'h00, 3, 25, 0, 0);
    chk("R4 refused byte_count", int'(byte_count), 63);
    chk("R4 refused msg_count", int'(msg_count), 5);
    chk("R4 overrun flags", int'({ovr_status, ovr_irq}), 3);
    read_at(0, v);
    chk("R4 head unchanged", v, 8'h88);
    read_at(1, v);
    chk("R4 head byte1", v, int'(pat(20, 1)));
    @(negedge clk); clr_ovr_cmd = 1;
    @(negedge clk); clr_ovr_cmd = 0;
    chk("R5 overrun cleared", int'({ovr_status, ovr_irq}), 0);
    do_release();
    chk("R7 byte_count", int'(byte_count), 50);
    chk("R7 msg_count", int'(msg_count), 4);
    send_rec(8'h08, 11, 26, 0, 1);
    send_rec(8'h00, 3, 27, 0, 1);
    chk("R4 exact fit accepted", int'(byte_count), 64);
    chk("R4 exact fit no overrun", int'(ovr_status), 0);
    for (int k = 13; k < 16; k++) begin
      read_at(k, v);
      chk("R8 offset beyond window", v, 0);
    end

    // Release coinciding with last byte of a store.
    do_release();
    chk("R7 byte_count", int'(byte_count), 51);
    send_rec(8'h02, 5, 28, 1, 1);
    chk("R11 combined byte_count", int'(byte_count), 43);
    chk("R11 combined msg_count", int'(msg_count), 5);
    read_at(0, v);
    chk("R11 new head", v, 8'h88);

    for (int j = 0; j < 5; j++) do_release();
    chk("R7 drained byte_count", int'(byte_count), 0);
    chk("R3 drained flags", int'({rx_status, rx_irq}), 0);
    do_release();
    chk("R6 release on empty", int'(msg_count), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule